// File: doc/BRIEF.md
# Five-Pin General-Purpose I/O Port with Standby Retention

This block is a five-pin general-purpose I/O port that sits on a microcontroller peripheral bus. Software reaches it through three registers. An output-value register holds the level each pin drives. A direction register sets each pin to drive or to float. A read-only port view returns, bit by bit, either the stored output value or the synchronized pin level. A pin whose direction bit is 1 drives its output-value bit. A pin whose direction bit is 0 has its output enable low.

The block has two low-power inputs, and each follows its own rule. Hardware standby clears every register and the synchronizer, which turns all pins into inputs. Software standby holds every register, including the port view, and ignores bus writes. Hardware standby takes precedence when both inputs are high.

The bus access is a single cycle with plain strobes. Writes are taken on the clock edge. Read data is combinational from the current state while the read strobe is high, so the interface has no back-pressure and needs no valid/ready handshake.

Top module: `gpio_standby_port`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, every register reads 0 and `pin_oe` and `pin_out` are all 0.
- R2: A write with `reg_sel`=0 loads `wr_data[4:0]` into the output-value register. A read with `reg_sel`=0 returns it in `rd_data[4:0]`. `rd_data[7:5]` always read 0.
- R3: A write with `reg_sel`=1 loads the direction register, and a read with `reg_sel`=1 returns it. `pin_oe[i]` equals direction bit i, and `pin_out[i]` equals output-value bit i.
- R4: A read with `reg_sel`=2 returns the port view. In the port view, bit i is output-value bit i when direction bit i is 1, and the synchronized `pin_in[i]` when direction bit i is 0.
- R5: A change on `pin_in` appears in the port view three clock edges later: two synchronizer stages, then the port-view register.
- R6: Writes with `reg_sel`=2 (port view) or `reg_sel`=3 (unused) change no register.
- R7: While `sw_stby` is high and `hw_stby` is low, writes are ignored, the output-value and direction registers hold their values, and the port view is frozen even if the pins change.
- R8: While `hw_stby` is high, every register and the synchronizer are cleared, even when `sw_stby` is also high. After release, the port view again follows the pins.
- R9: While `rd_en` is low, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby; clears state |
| sw_stby | input | 1 | Software standby; holds state |
| reg_sel | input | 2 | Register select: 0 output value, 1 direction, 2 port view, 3 unused |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| pin_in | input | 5 | Pin levels, asynchronous |
| pin_out | output | 5 | Driven pin levels |
| pin_oe | output | 5 | Pin output enables |

## Verification
Two collisions can fall in the same cycle. The first is a register write in the same cycle that a standby input rises. The second is hardware standby asserted together with software standby. The bench provokes both with directed steps and with random stimulus in which write strobes, select values and both standby inputs change every cycle. Each cycle it compares the read data and the pin outputs with a reference model built from the requirements. In that model, a write during software standby is dropped and hardware standby overrides everything.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_OUTVAL = 2'd0,
    SEL_DIRECT = 2'd1,
    SEL_VIEW   = 2'd2,
    SEL_UNUSED = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stg[s] <= '0;
      else if (clr) stg[s] <= '0;
      else if (s == 0) stg[s] <= async_in;
      else          stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_port_pkg::*;
#(
  parameter int W     = 5,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [BUS_W-1:0] wr_data,
  output logic [W-1:0]     outval_q,
  output logic [W-1:0]     dir_q
);
  logic wr_ok;
  assign wr_ok = wr_en && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outval_q <= '0;
      dir_q    <= '0;
    end else if (clr) begin
      outval_q <= '0;
      dir_q    <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_OUTVAL: outval_q <= wr_data[W-1:0];
        SEL_DIRECT: dir_q    <= wr_data[W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_view.sv
module gpio_port_view #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         hold,
  input  logic [W-1:0] outval,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] view_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic sel_bit;
    assign sel_bit = dir[i] ? outval[i] : pin_sync[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     view_q[i] <= 1'b0;
      else if (clr)   view_q[i] <= 1'b0;
      else if (!hold) view_q[i] <= sel_bit;
    end
  end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_port_pkg::*;
#(
  parameter int W     = 5,
  parameter int BUS_W = 8
) (
  input  logic             rd_en,
  input  reg_sel_e         sel,
  input  logic [W-1:0]     outval,
  input  logic [W-1:0]     dir,
  input  logic [W-1:0]     view,
  output logic [BUS_W-1:0] rd_data
);
  logic [W-1:0] pick;
  always_comb begin
    case (sel)
      SEL_OUTVAL: pick = outval;
      SEL_DIRECT: pick = dir;
      SEL_VIEW:   pick = view;
      default:    pick = '0;
    endcase
  end
  assign rd_data = rd_en ? {{(BUS_W-W){1'b0}}, pick} : '0;
endmodule

// File: rtl/gpio_standby_port.sv
module gpio_standby_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_W       = 5,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic [1:0]       reg_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] pin_out,
  output logic [PIN_W-1:0] pin_oe
);
  reg_sel_e     sel;
  logic         hold;
  logic [PIN_W-1:0] outval_q, dir_q, pin_sync, view_q;

  assign sel  = reg_sel_e'(reg_sel);
  assign hold = sw_stby && !hw_stby;

  gpio_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .clr(hw_stby),
    .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_ctrl_regs #(.W(PIN_W), .BUS_W(BUS_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .clr(hw_stby), .hold(hold),
    .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
    .outval_q(outval_q), .dir_q(dir_q)
  );

  gpio_port_view #(.W(PIN_W)) view_i (
    .clk(clk), .rst_n(rst_n), .clr(hw_stby), .hold(hold),
    .outval(outval_q), .dir(dir_q), .pin_sync(pin_sync), .view_q(view_q)
  );

  gpio_rd_mux #(.W(PIN_W), .BUS_W(BUS_W)) rmux_i (
    .rd_en(rd_en), .sel(sel), .outval(outval_q), .dir(dir_q),
    .view(view_q), .rd_data(rd_data)
  );

  assign pin_out = outval_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_standby_port_chk.sv
module gpio_standby_port_chk #(
  parameter int PIN_W = 5,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_stby,
  input logic             sw_stby,
  input logic [1:0]       reg_sel,
  input logic             wr_en,
  input logic             rd_en,
  input logic [BUS_W-1:0] rd_data,
  input logic [PIN_W-1:0] pin_out,
  input logic [PIN_W-1:0] pin_oe
);
  // R8: hardware standby leaves pins undriven and zero on the next cycle
  a_r8_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (pin_oe == '0 && pin_out == '0));

  // R7: software standby freezes pin-facing registers
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R6: writes to port view or unused select change nothing
  a_r6_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel[1] && !hw_stby) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R9: idle read bus is zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);

  // R2: upper bits read zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:PIN_W] == '0);

  // R3: output-value read agrees with the driven pin levels
  a_r3_out_match: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == 2'd0) |-> rd_data[PIN_W-1:0] == pin_out);
endmodule

bind gpio_standby_port gpio_standby_port_chk #(.PIN_W(PIN_W), .BUS_W(BUS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
  .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_standby_port_tb_top.sv
module gpio_standby_port_tb_top;
  localparam int CLK_NS = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_stby = 1'b0, sw_stby = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [4:0] pin_in = '0, pin_out, pin_oe;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_standby_port dut_i (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Reference model from the requirements
  logic [4:0] m_out = '0, m_dir = '0, m_s1 = '0, m_s2 = '0, m_view = '0;
  always @(posedge clk) begin
    if (!rst_n || hw_stby) begin               // R1, R8
      m_out <= '0; m_dir <= '0; m_s1 <= '0; m_s2 <= '0; m_view <= '0;
    end else begin
      m_s1 <= pin_in; m_s2 <= m_s1;            // R5
      if (!sw_stby) begin                      // R7
        if (wr_en && reg_sel == 2'd0) m_out <= wr_data[4:0];  // R2
        if (wr_en && reg_sel == 2'd1) m_dir <= wr_data[4:0];  // R3
        m_view <= (m_dir & m_out) | (~m_dir & m_s2);          // R4
      end
    end
  end

  function automatic logic [7:0] exp_rd(logic en, logic [1:0] s,
                                        logic [4:0] o, logic [4:0] d, logic [4:0] v);
    if (!en) return 8'h00;                     // R9
    case (s)
      2'd0: return {3'b000, o};
      2'd1: return {3'b000, d};
      2'd2: return {3'b000, v};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n !== 1'bx && !done) begin
    check(tag, rd_data, exp_rd(rd_en, reg_sel, m_out, m_dir, m_view));
    check("R3", {3'b0, pin_oe}, {3'b0, m_dir});
    check("R3", {3'b0, pin_out}, {3'b0, m_out});
  end

  task automatic cyc(logic we, logic re, logic [1:0] s, logic [7:0] d,
                     logic [4:0] p, logic hw, logic sw);
    @(posedge clk); #1;
    wr_en = we; rd_en = re; reg_sel = s; wr_data = d; pin_in = p;
    hw_stby = hw; sw_stby = sw;
  endtask

  task automatic summary;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [4:0] held;
    void'($urandom(32'h5eed_0a17));
    tag = "R1";
    for (int k = 0; k < 3; k++) cyc(0, 1, 2'(k), 8'h00, 5'h1f, 0, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    for (int k = 0; k < 4; k++) cyc(0, 1, 2'(k), 8'h00, 5'h00, 0, 0);
    tag = "R2";
    cyc(1, 0, 2'd0, 8'hff, 5'h00, 0, 0);
    cyc(0, 1, 2'd0, 8'h00, 5'h00, 0, 0);
    cyc(1, 1, 2'd0, 8'hea, 5'h00, 0, 0);
    tag = "R3";
    cyc(1, 0, 2'd1, 8'he5, 5'h00, 0, 0);
    cyc(0, 1, 2'd1, 8'h00, 5'h00, 0, 0);
    tag = "R4";
    for (int k = 0; k < 6; k++) cyc(0, 1, 2'd2, 8'h00, 5'(k * 7), 0, 0);
    tag = "R5";
    cyc(1, 0, 2'd1, 8'h00, 5'h00, 0, 0);
    for (int k = 0; k < 4; k++) cyc(0, 1, 2'd2, 8'h00, 5'h00, 0, 0);
    cyc(0, 1, 2'd2, 8'h00, 5'h15, 0, 0);
    cyc(0, 1, 2'd2, 8'h00, 5'h15, 0, 0);
    cyc(0, 1, 2'd2, 8'h00, 5'h15, 0, 0);
    check("R5", rd_data, 8'h00);             // two edges after change: not yet
    cyc(0, 1, 2'd2, 8'h00, 5'h15, 0, 0);
    #1 check("R5", rd_data, 8'h15);          // third edge: visible
    tag = "R6";
    cyc(1, 0, 2'd0, 8'h0c, 5'h15, 0, 0);
    cyc(1, 0, 2'd1, 8'h03, 5'h15, 0, 0);
    cyc(1, 0, 2'd2, 8'hff, 5'h15, 0, 0);
    cyc(1, 0, 2'd3, 8'hff, 5'h15, 0, 0);
    cyc(0, 1, 2'd0, 8'h00, 5'h15, 0, 0);
    cyc(0, 1, 2'd1, 8'h00, 5'h15, 0, 0);
    tag = "R7";
    cyc(0, 1, 2'd2, 8'h00, 5'h15, 0, 0);
    cyc(0, 1, 2'd2, 8'h00, 5'h15, 0, 0);
    held = rd_data[4:0];
    cyc(1, 1, 2'd0, 8'h1f, 5'h0a, 0, 1);
    for (int k = 0; k < 5; k++) cyc(1, 1, 2'd1, 8'h1f, 5'(k + 9), 0, 1);
    cyc(0, 1, 2'd2, 8'h00, 5'h0a, 0, 1);
    #1 check("R7", rd_data, {3'b0, held});
    tag = "R8";
    cyc(1, 1, 2'd0, 8'h1f, 5'h0a, 1, 1);
    cyc(0, 1, 2'd0, 8'h00, 5'h0a, 1, 1);
    #1 check("R8", {3'b0, pin_oe}, 8'h00);
    for (int k = 0; k < 5; k++) cyc(0, 1, 2'd2, 8'h00, 5'h0a, 0, 0);
    #1 check("R8", rd_data, 8'h0a);
    tag = "R9";
    for (int k = 0; k < 4; k++) cyc(1, 0, 2'(k), 8'h1b, 5'h11, 0, 0);
    tag = "";
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] r;
      r = 4'($urandom);
      cyc(1'($urandom), ($urandom % 4) != 0, 2'($urandom), 8'($urandom),
          5'($urandom), r == 0, r < 3);
      tag = hw_stby ? "R8" : sw_stby ? "R7" : !rd_en ? "R9" :
            reg_sel == 2'd2 ? "R4" : reg_sel == 2'd0 ? "R2" :
            reg_sel == 2'd1 ? "R3" : "R6";
    end
    cyc(0, 0, 2'd0, 8'h00, 5'h00, 0, 0);
    @(posedge clk); #1;
    summary();
  end
endmodule